// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits between fifteen peripheral interrupt sources and a CPU core. Peripheral events set request flags in a pending register. Software can read and write that register, subject to per-flag rules. Software can also program a per-source enable mask, a global enable, and two priority words. Taken together, the two priority words give each source one of four levels. From all the pending, enabled and eligible sources, the block picks one winner. It then raises a request to the core with the winner's source index and vector address.

When the core acknowledges, the block marks the winner's level as in service. While a level is in service, only requests at a strictly higher level can reach the core, so interrupts nest. A return pulse from the core closes the innermost active level, and the interrupted lower level then resumes. Flags are never cleared by the controller itself. Software clears them from inside the handler.

Software access uses one write strobe, a 2-bit register select and a 16-bit data word. Select 0 is the pending flags, 1 is the enables, 2 is the priority low word and 3 is the priority high word. Readback is combinational.

Top module: `nic_top`

## Requirements
- R1: After reset, all four software registers read as zero, no source is in service, and `irq_req` is low.
- R2: A one-cycle `hw_evt` pulse sets its flag, with `hw_evt[13]` setting flag 15 (16-bit timer overflow) and every other `hw_evt[i]` setting flag i. The controller never clears a flag by itself, and this holds after an acknowledge too.
- R3: A write to select 0 sets or clears flags exactly as hardware events do, so software can raise a request. The exception is flag 10 (converter done), which a write can clear but never set.
- R4: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R5: Source 14 requests whenever flag 14 (8-bit timer overflow) or flag 15 (16-bit timer overflow) is set.
- R6: Source 13 requests whenever `can_status` is nonzero, with one cycle of latency. Flag bit 13 reads that condition, software writes to bit 13 have no effect, and the vector is 0x006B.
- R7: Enable register bits 14:0 gate each source, and bit 15 is the global enable. No request is raised while the global enable is clear.
- R8: A source's level is {priority high bit, priority low bit}, where 3 is the highest and 0 the lowest. Among eligible sources the highest level wins, and on a tie the lowest source index wins.
- R9: `irq_vec` equals 0x0003 + 8 × `irq_id`. `irq_req` rises one cycle after a source becomes eligible. Once raised, `irq_req`, `irq_id` and `irq_vec` stay unchanged until `irq_ack`.
- R10: `irq_ack` while `irq_req` is high marks the winner's level as in service. A source is eligible only if its level is above the highest level in service, so a request at an equal or lower level waits.
- R11: An `irq_reti` pulse ends the highest level in service. A request at a level above the new highest level is then raised again, so a preempted handler's level resumes below a finished higher one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_evt | input | 15 | Hardware flag set pulses (bit 13 sets the 16-bit overflow flag) |
| can_status | input | 8 | CAN status; any set bit requests source 13 |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 2 | Register select: 0 flags, 1 enables, 2 priority low, 3 priority high |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Readback of the selected register |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | 4 | Winning source index |
| irq_vec | output | 16 | Winning vector address |
| irq_ack | input | 1 | Core accepts the request |
| irq_reti | input | 1 | Core returns from the current handler |

## Verification
The bench builds the block with its default parameters: fifteen sources, four levels and a 16-bit vector. With these values every source index and every level code can be programmed. This includes the CAN source at index 13, which lands on vector 0x006B, and the split overflow source at index 14. A vector table covers the arbitration cases. Directed sequences then nest level 0 under level 2, hold back an equal-level request, and resume after a return.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int NSRC    = 15;
    localparam int NFLAG   = 16;
    localparam int NLVL    = 4;
    localparam int LVLW    = $clog2(NLVL);
    localparam int IDW     = $clog2(NSRC);
    localparam int VECW    = 16;
    localparam int CANW    = 8;
    localparam int SWW     = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP_SH = 3;

    localparam int SRC_CAN   = 13;
    localparam int SRC_TOVF  = 14;
    localparam int FLG_ADC   = 10;
    localparam int FLG_OVF8  = 14;
    localparam int FLG_OVF16 = 15;
    localparam int GE_BIT    = 15;

    typedef logic [LVLW-1:0] level_t;

    typedef enum logic [1:0] {
        SEL_FLAGS   = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_PRIO_LO = 2'd2,
        SEL_PRIO_HI = 2'd3
    } sw_sel_e;

    typedef struct packed {
        logic           valid;
        logic [IDW-1:0] id;
        level_t         lvl;
    } pick_t;

    // Flags software may set: all but the converter-done flag and the CAN mirror.
    function automatic logic [NFLAG-1:0] sw_set_mask();
        logic [NFLAG-1:0] m;
        for (int i = 0; i < NFLAG; i++)
            m[i] = (i != FLG_ADC) && (i != SRC_CAN);
        return m;
    endfunction

    // Flags software may clear: all but the CAN mirror.
    function automatic logic [NFLAG-1:0] sw_clr_mask();
        logic [NFLAG-1:0] m;
        for (int i = 0; i < NFLAG; i++)
            m[i] = (i != SRC_CAN);
        return m;
    endfunction

    function automatic logic [VECW-1:0] vec_of(logic [IDW-1:0] id);
        return VECW'(VEC_BASE) + (VECW'(id) << VEC_STEP_SH);
    endfunction

endpackage

// File: rtl/nic_flags.sv
module nic_flags
    import nic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] hw_set,
    input  logic [NFLAG-1:0] hw_clr,
    input  logic [NFLAG-1:0] sw_set,
    input  logic [NFLAG-1:0] sw_clr,
    output logic [NFLAG-1:0] flags_q
);

    // Set sources dominate clears so that a coincident event is never lost.
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[i] <= 1'b0;
            else
                flags_q[i] <= hw_set[i] | sw_set[i] |
                              (flags_q[i] & ~sw_clr[i] & ~hw_clr[i]);
        end
    end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    input  logic            ge,
    input  logic [NSRC-1:0] prio_lo,
    input  logic [NSRC-1:0] prio_hi,
    input  logic            thr_any,
    input  level_t          thr_lvl,
    output pick_t           pick
);

    level_t lvl;

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        pick = '0;
        lvl  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            lvl = {prio_hi[i], prio_lo[i]};
            if (req[i] && en[i] && ge && (!thr_any || lvl > thr_lvl)) begin
                if (!pick.valid || lvl >= pick.lvl) begin
                    pick.valid = 1'b1;
                    pick.id    = IDW'(i);
                    pick.lvl   = lvl;
                end
            end
        end
    end

endmodule

// File: rtl/nic_inservice.sv
module nic_inservice
    import nic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  level_t          push_lvl,
    input  logic            pop,
    output logic [NLVL-1:0] mask_q,
    output logic            any,
    output level_t          top
);

    logic [NLVL-1:0] after_pop;

    always_comb begin
        top = '0;
        for (int l = 0; l < NLVL; l++)
            if (mask_q[l]) top = level_t'(l);
    end

    assign any = |mask_q;

    always_comb begin
        after_pop = mask_q;
        if (pop && any)
            after_pop[top] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (push)
            mask_q <= after_pop | (NLVL'(1) << push_lvl);
        else
            mask_q <= after_pop;
    end

endmodule

// File: rtl/nic_top.sv
module nic_top
    import nic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] hw_evt,
    input  logic [CANW-1:0] can_status,
    input  logic            sw_wr,
    input  logic [1:0]      sw_sel,
    input  logic [SWW-1:0]  sw_wdata,
    output logic [SWW-1:0]  sw_rdata,
    output logic            irq_req,
    output logic [IDW-1:0]  irq_id,
    output logic [VECW-1:0] irq_vec,
    input  logic            irq_ack,
    input  logic            irq_reti
);

    localparam logic [NFLAG-1:0] SET_OK = sw_set_mask();
    localparam logic [NFLAG-1:0] CLR_OK = sw_clr_mask();

    sw_sel_e          sel;
    logic             can_nz;
    logic             wr_flags;
    logic [NFLAG-1:0] hw_set, hw_clr, sw_set, sw_clr, flags_q;
    logic [SWW-1:0]   en_q;
    logic [NSRC-1:0]  plo_q, phi_q;
    logic [NSRC-1:0]  src_req;
    logic [NLVL-1:0]  isr_mask;
    logic             isr_any;
    level_t           isr_top;
    pick_t            pick, req_q;
    logic             take;

    assign sel      = sw_sel_e'(sw_sel);
    assign can_nz   = |can_status;
    assign wr_flags = sw_wr && (sel == SEL_FLAGS);

    // Event bit 13 is the 16-bit overflow; the CAN flag mirrors its status.
    always_comb begin
        hw_set = '0;
        hw_clr = '0;
        for (int i = 0; i < NSRC; i++)
            if (i != SRC_CAN) hw_set[i] = hw_evt[i];
        hw_set[FLG_OVF16] = hw_evt[SRC_CAN];
        hw_set[SRC_CAN]   = can_nz;
        hw_clr[SRC_CAN]   = ~can_nz;
    end

    assign sw_set = wr_flags ? (sw_wdata  & SET_OK) : '0;
    assign sw_clr = wr_flags ? (~sw_wdata & CLR_OK) : '0;

    nic_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .hw_set  (hw_set),
        .hw_clr  (hw_clr),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .flags_q (flags_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            plo_q <= '0;
            phi_q <= '0;
        end else if (sw_wr) begin
            case (sel)
                SEL_ENABLE:  en_q  <= sw_wdata;
                SEL_PRIO_LO: plo_q <= sw_wdata[NSRC-1:0];
                SEL_PRIO_HI: phi_q <= sw_wdata[NSRC-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_FLAGS:   sw_rdata = flags_q;
            SEL_ENABLE:  sw_rdata = en_q;
            SEL_PRIO_LO: sw_rdata = {{(SWW-NSRC){1'b0}}, plo_q};
            default:     sw_rdata = {{(SWW-NSRC){1'b0}}, phi_q};
        endcase
    end

    // Source 14 merges both overflow flags.
    always_comb begin
        src_req = flags_q[NSRC-1:0];
        src_req[SRC_TOVF] = flags_q[FLG_OVF8] | flags_q[FLG_OVF16];
    end

    nic_arbiter u_arb (
        .req     (src_req),
        .en      (en_q[NSRC-1:0]),
        .ge      (en_q[GE_BIT]),
        .prio_lo (plo_q),
        .prio_hi (phi_q),
        .thr_any (isr_any),
        .thr_lvl (isr_top),
        .pick    (pick)
    );

    assign take = req_q.valid && irq_ack;

    nic_inservice u_isr (
        .clk      (clk),
        .rst      (rst),
        .push     (take),
        .push_lvl (req_q.lvl),
        .pop      (irq_reti),
        .mask_q   (isr_mask),
        .any      (isr_any),
        .top      (isr_top)
    );

    // Winner is captured once and held until the core accepts it.
    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (req_q.valid) begin
            if (irq_ack) req_q <= '0;
        end else if (pick.valid)
            req_q <= pick;
    end

    assign irq_req = req_q.valid;
    assign irq_id  = req_q.id;
    assign irq_vec = vec_of(req_q.id);

endmodule

// File: rtl/nic_chk.sv
module nic_chk
    import nic_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq_req,
    input logic [IDW-1:0]   irq_id,
    input level_t           irq_lvl,
    input logic             irq_ack,
    input logic             irq_reti,
    input logic             ge,
    input logic [NLVL-1:0]  isr_mask,
    input logic [NFLAG-1:0] flags,
    input logic             sw_wr,
    input logic [1:0]       sw_sel,
    input logic [NSRC-1:0]  hw_evt
);

    localparam logic [NFLAG-1:0] STORED = ~(NFLAG'(1) << SRC_CAN);

    logic [NLVL-1:0] prev_mask;
    logic            prev_any;
    level_t          prev_top;

    always_ff @(posedge clk) begin
        if (rst) prev_mask <= '0;
        else     prev_mask <= isr_mask;
    end

    always_comb begin
        prev_top = '0;
        for (int l = 0; l < NLVL; l++)
            if (prev_mask[l]) prev_top = level_t'(l);
    end
    assign prev_any = |prev_mask;

    // R9
    held_req_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req && !irq_ack |=> irq_req && $stable(irq_id));

    // R7
    ge_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(ge));

    // R10
    ack_mark_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req && irq_ack && !irq_reti |=> isr_mask[$past(irq_lvl)]);

    // R10
    eligible_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> (!prev_any || irq_lvl > prev_top));

    // R11
    reti_pop_chk: assert property (@(posedge clk) disable iff (rst)
        irq_reti && !(irq_req && irq_ack) && (isr_mask != '0)
        |=> $countones(isr_mask) == $countones($past(isr_mask)) - 1);

    // R2
    no_hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !(sw_wr && sw_sel == 2'd0)
        |=> ((flags & $past(flags) & STORED) == ($past(flags) & STORED)));

    // R3
    adc_noset_chk: assert property (@(posedge clk) disable iff (rst)
        sw_wr && sw_sel == 2'd0 && !flags[FLG_ADC] && !hw_evt[FLG_ADC]
        |=> !flags[FLG_ADC]);

endmodule

bind nic_top nic_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .irq_id   (irq_id),
    .irq_lvl  (req_q.lvl),
    .irq_ack  (irq_ack),
    .irq_reti (irq_reti),
    .ge       (en_q[15]),
    .isr_mask (isr_mask),
    .flags    (flags_q),
    .sw_wr    (sw_wr),
    .sw_sel   (sw_sel),
    .hw_evt   (hw_evt)
);

// File: tb/nic_top_tb.sv
module nic_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] hw_evt = '0;
    logic [7:0]  can_status = '0;
    logic        sw_wr = 1'b0;
    logic [1:0]  sw_sel = '0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] sw_rdata;
    logic        irq_req;
    logic [3:0]  irq_id;
    logic [15:0] irq_vec;
    logic        irq_ack = 1'b0;
    logic        irq_reti = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nic_top u_dut (
        .clk(clk), .rst(rst), .hw_evt(hw_evt), .can_status(can_status),
        .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .irq_reti(irq_reti)
    );

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] en;
        logic [14:0] lo;
        logic [14:0] hi;
        logic        req;
        logic [3:0]  id;
    } vec_t;

    localparam vec_t TAB [8] = '{
        '{16'h0001, 16'h8001, 15'h0000, 15'h0000, 1'b1, 4'd0},
        '{16'h0006, 16'h8006, 15'h0004, 15'h0000, 1'b1, 4'd2},
        '{16'h0030, 16'h8030, 15'h0030, 15'h0030, 1'b1, 4'd4},
        '{16'h1000, 16'h1000, 15'h0000, 15'h0000, 1'b0, 4'd0},
        '{16'h0300, 16'h8100, 15'h0000, 15'h0000, 1'b1, 4'd8},
        '{16'h8000, 16'hC000, 15'h0000, 15'h0000, 1'b1, 4'd14},
        '{16'h4000, 16'hC000, 15'h0000, 15'h0000, 1'b1, 4'd14},
        '{16'h0801, 16'h8801, 15'h0000, 15'h0800, 1'b1, 4'd11}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        sw_sel = sel; sw_wdata = d; sw_wr = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        sw_sel = sel;
        #1;
        d = sw_rdata;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        irq_reti = 1'b1; @(negedge clk); irq_reti = 1'b0;
    endtask

    task automatic pulse_evt(input int i);
        hw_evt[i] = 1'b1; @(negedge clk); hw_evt[i] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        check("R1 irq_req", irq_req, 0);
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), d);
            check("R1 register", d, 0);
        end

        // R2 hardware set, no hardware clear on acknowledge
        pulse_evt(6);
        rd(0, d); check("R2 evt sets flag 6", d, 16'h0040);
        pulse_evt(13);
        rd(0, d); check("R2 evt13 sets flag 15", d, 16'h8040);
        wr(0, 16'h0040);
        wr(1, 16'h8040);
        cyc(1);
        check("R2 req", irq_req, 1);
        check("R2 id", irq_id, 6);
        pulse_ack();
        cyc(2);
        rd(0, d); check("R2 flag kept after ack", d, 16'h0040);
        wr(0, 16'h0000);
        pulse_reti();
        wr(1, 16'h0000);

        // R3 software set and clear, converter-done clear-only
        wr(0, 16'h0408);
        rd(0, d); check("R3 sw set, adc not set", d, 16'h0008);
        pulse_evt(10);
        rd(0, d); check("R3 adc hw set", d, 16'h0408);
        wr(0, 16'h0000);
        rd(0, d); check("R3 sw clear", d, 16'h0000);

        // R4 coincident hardware set and software clear
        wr(0, 16'h0020);
        hw_evt[5] = 1'b1;
        wr(0, 16'h0000);
        hw_evt[5] = 1'b0;
        rd(0, d); check("R4 set wins", d, 16'h0020);
        wr(0, 16'h0000);

        // R6 CAN source
        wr(1, 16'hA000);
        can_status = 8'h04;
        cyc(2);
        check("R6 req", irq_req, 1);
        check("R6 id", irq_id, 13);
        check("R6 vec", irq_vec, 16'h006B);
        wr(0, 16'h0000);
        rd(0, d); check("R6 write ignored", d, 16'h2000);
        pulse_ack();
        can_status = 8'h00;
        cyc(2);
        rd(0, d); check("R6 status gone", d, 16'h0000);
        pulse_reti();

        // R9 / R10 / R11 nesting
        wr(2, 16'h0000);
        wr(3, 16'h0088);
        wr(1, 16'h8089);
        wr(0, 16'h0001);
        cyc(1);
        check("R10 level0 req", irq_req, 1);
        check("R10 level0 id", irq_id, 0);
        wr(0, 16'h0009);
        cyc(1);
        check("R9 held id", irq_id, 0);
        check("R9 held vec", irq_vec, 16'h0003);
        pulse_ack();
        cyc(1);
        check("R10 preempt req", irq_req, 1);
        check("R10 preempt id", irq_id, 3);
        pulse_ack();
        wr(0, 16'h0081);
        cyc(3);
        check("R10 equal level waits", irq_req, 0);
        pulse_reti();
        cyc(1);
        check("R11 resume req", irq_req, 1);
        check("R11 resume id", irq_id, 7);
        pulse_ack();
        wr(0, 16'h0000);
        pulse_reti();
        pulse_reti();
        wr(0, 16'h0001);
        cyc(1);
        check("R11 all levels closed", irq_req, 1);
        pulse_ack();
        wr(0, 16'h0000);
        pulse_reti();

        // R5 R7 R8 R9 vector table
        foreach (TAB[k]) begin
            wr(1, TAB[k].en);
            wr(2, {1'b0, TAB[k].lo});
            wr(3, {1'b0, TAB[k].hi});
            wr(0, TAB[k].flags);
            cyc(1);
            check("R8 table req", irq_req, TAB[k].req);
            if (TAB[k].req) begin
                check("R8 table id", irq_id, TAB[k].id);
                check("R9 table vec", irq_vec, 16'h0003 + 16'(TAB[k].id) * 8);
                pulse_ack();
            end
            wr(0, 16'h0000);
            pulse_reti();
        end

        cyc(2);
        finish_run();
    end

endmodule